// File: doc/BRIEF.md
# AUX Channel Message Register Bank

This block is the register file a host uses to run one message exchange on a DisplayPort-style AUX channel engine. It holds a control/status word and five 32-bit data words, which together form a 20-byte message buffer. The host loads the outgoing bytes into the data words, then writes the control word with the busy bit set and the transmit size in the size field. The block then sends the engine a one-cycle start pulse together with that size. The engine reads the outgoing bytes one at a time by index, writes the reply bytes back into the same buffer, and ends the transaction with a completion strobe that carries its error flags and the reply length.

The bank records the outcome in sticky flags that the host clears by writing 1 to them. It checks the reply length and marks lengths that cannot be valid. It also drives a level interrupt while the done flag is set and interrupts are enabled.

Top module: `aux_msg_regbank`

## Requirements
- R1: After reset, the control word, all five data words, `irq` and `eng_start` read 0.
- R2: Address 0 is the control word. Addresses 1 to 5 are data words 0 to 4. Data word k holds buffer bytes 4k to 4k+3, with byte 4k+i in bits [31-8i:24-8i], so the first byte of each word sits in the top lane. While a transfer runs, buffer byte n is presented on `eng_tx_byte` when `eng_byte_idx` is n.
- R3: A buffer byte whose index is at or above the transmit size is presented to the engine as 0, so the unused lower lanes of a trailing partial word never reach the engine.
- R4: A control write with bit 31 (busy) set while the bank is idle does three things: busy reads 1 from the next cycle, `eng_start` is 1 for exactly the cycle after the write, and `eng_tx_len` carries control bits [24:20] from the write.
- R5: Busy stays 1 until `eng_done`. The cycle after `eng_done`, busy is 0, bit 30 (done) is 1, bit 29 (timeout) is 1 if `eng_timeout` was 1, and bit 28 (receive error) is 1 if `eng_rx_err` was 1.
- R6: Writing 1 to bit 30, 29 or 28 clears only that flag, and writing 0 leaves it unchanged. If a completion arrives in the same cycle as the clearing write, the completion wins.
- R7: After completion, control bits [24:20] read the reply length, and reply bytes that the engine wrote read back through the data words.
- R8: Bit 27 (size illegal) is set at completion when the reply length is 0 or greater than 20, and cleared when the length lies in 1 to 20. An accepted start clears it.
- R9: Data-word writes while busy is 1 are ignored.
- R10: A control write with busy set while a transfer runs starts nothing. No `eng_start` pulse follows, and `eng_tx_len` is unchanged.
- R11: Control bit 26 is the interrupt enable. It is written by every control write and reads back. `irq` equals done AND the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 3 | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 3 | Host read word address |
| host_rdata | output | 32 | Read data for `host_raddr` (combinational) |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle transaction start to the engine |
| eng_tx_len | output | 5 | Transmit byte count for the engine |
| eng_byte_idx | input | 5 | Engine transmit byte index |
| eng_tx_byte | output | 8 | Transmit byte at `eng_byte_idx` |
| eng_rx_we | input | 1 | Engine reply byte write strobe |
| eng_rx_idx | input | 5 | Reply byte index |
| eng_rx_byte | input | 8 | Reply byte value |
| eng_done | input | 1 | Engine completion strobe |
| eng_timeout | input | 1 | Completion ended in timeout |
| eng_rx_err | input | 1 | Completion ended with a receive error |
| eng_rx_len | input | 5 | Number of reply bytes received |

## Verification
Reads and byte lookups are combinational, so the bench samples `host_rdata` and `eng_tx_byte` one time step after it changes the address, at a falling edge, in a cycle where nothing is being written. A write or a completion strobe is held across one rising edge, and its effects (flags, stored bytes, size field) are due right after that edge. The start pulse is due in the cycle that follows the accepting edge and must be gone one edge later. The bench checks it at exactly those two points. The interrupt follows the registered done and enable bits with no added delay, so it is checked in the same cycle as the flags.

// File: rtl/aux_regbank_pkg.sv
package aux_regbank_pkg;
  localparam int unsigned BIT_BUSY = 31;
  localparam int unsigned BIT_DONE = 30;
  localparam int unsigned BIT_TMO  = 29;
  localparam int unsigned BIT_RXE  = 28;
  localparam int unsigned BIT_BAD  = 27;
  localparam int unsigned BIT_IEN  = 26;
  localparam int unsigned SIZE_LSB = 20;

  // first byte of a group goes to the top lane
  function automatic logic [31:0] pack_be(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3);
    return {b0, b1, b2, b3};
  endfunction

  function automatic logic [7:0] lane_of(input logic [31:0] w, input int unsigned i);
    return w[31-8*i -: 8];
  endfunction

  function automatic logic size_illegal(input int unsigned len, input int unsigned max_len);
    return (len == 0) || (len > max_len);
  endfunction
endpackage

// File: rtl/aux_ctl_status.sv
module aux_ctl_status
  import aux_regbank_pkg::*;
#(
  parameter int unsigned LEN_W     = 5,
  parameter int unsigned MAX_BYTES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             eng_done,
  input  logic             eng_timeout,
  input  logic             eng_rx_err,
  input  logic [LEN_W-1:0] eng_rx_len,
  output logic             busy,
  output logic             done,
  output logic             tmo_err,
  output logic             rx_err,
  output logic             size_bad,
  output logic             irq_en,
  output logic [LEN_W-1:0] msg_size,
  output logic             start_pulse,
  output logic             finish_evt
);
  logic accept;
  logic clr_done, clr_tmo, clr_rxe;

  assign accept     = ctl_we && ctl_wdata[BIT_BUSY] && !busy;
  assign finish_evt = busy && eng_done;
  assign clr_done   = ctl_we && ctl_wdata[BIT_DONE];
  assign clr_tmo    = ctl_we && ctl_wdata[BIT_TMO];
  assign clr_rxe    = ctl_we && ctl_wdata[BIT_RXE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      tmo_err     <= 1'b0;
      rx_err      <= 1'b0;
      size_bad    <= 1'b0;
      irq_en      <= 1'b0;
      msg_size    <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= accept;
      if (ctl_we) irq_en <= ctl_wdata[BIT_IEN];
      if (accept) begin
        busy     <= 1'b1;
        msg_size <= ctl_wdata[SIZE_LSB +: LEN_W];
        size_bad <= 1'b0;
      end else if (finish_evt) begin
        busy     <= 1'b0;
        msg_size <= eng_rx_len;
        size_bad <= size_illegal(32'(eng_rx_len), MAX_BYTES);
      end
      // completion sets win over a clearing write in the same cycle
      done    <= finish_evt || (done && !clr_done);
      tmo_err <= (finish_evt && eng_timeout) || (tmo_err && !clr_tmo);
      rx_err  <= (finish_evt && eng_rx_err) || (rx_err && !clr_rxe);
    end
  end
endmodule

// File: rtl/aux_msg_buffer.sv
module aux_msg_buffer
  import aux_regbank_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned LEN_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_word,
  input  logic [31:0]       host_wdata,
  input  logic              rx_we,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [7:0]        rx_byte,
  input  logic [ADDR_W-1:0] rd_word_sel,
  output logic [31:0]       rd_word,
  input  logic [IDX_W-1:0]  tx_idx,
  input  logic [LEN_W-1:0]  tx_len,
  output logic [7:0]        tx_byte
);
  localparam int unsigned NUM_BYTES = 4 * NUM_WORDS;

  logic [7:0] mem [NUM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_BYTES; n++) mem[n] <= '0;
    end else begin
      if (host_we && (32'(host_word) < NUM_WORDS)) begin
        for (int i = 0; i < 4; i++)
          mem[32'(host_word) * 4 + 32'(i)] <= lane_of(host_wdata, i);
      end
      if (rx_we && (32'(rx_idx) < NUM_BYTES))
        mem[32'(rx_idx)] <= rx_byte;
    end
  end

  always_comb begin
    rd_word = '0;
    if (32'(rd_word_sel) < NUM_WORDS)
      rd_word = pack_be(mem[32'(rd_word_sel) * 4],     mem[32'(rd_word_sel) * 4 + 1],
                        mem[32'(rd_word_sel) * 4 + 2], mem[32'(rd_word_sel) * 4 + 3]);
  end

  always_comb begin
    tx_byte = '0;
    if ((32'(tx_idx) < 32'(tx_len)) && (32'(tx_idx) < NUM_BYTES))
      tx_byte = mem[32'(tx_idx)];
  end
endmodule

// File: rtl/aux_msg_regbank.sv
module aux_msg_regbank
  import aux_regbank_pkg::*;
#(
  parameter  int unsigned NUM_WORDS = 5,
  localparam int unsigned MSG_BYTES = 4 * NUM_WORDS,
  localparam int unsigned ADDR_W    = $clog2(NUM_WORDS + 1),
  localparam int unsigned IDX_W     = $clog2(MSG_BYTES),
  localparam int unsigned LEN_W     = $clog2(MSG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [31:0]       host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [31:0]       host_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic [LEN_W-1:0]  eng_tx_len,
  input  logic [IDX_W-1:0]  eng_byte_idx,
  output logic [7:0]        eng_tx_byte,
  input  logic              eng_rx_we,
  input  logic [IDX_W-1:0]  eng_rx_idx,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_done,
  input  logic              eng_timeout,
  input  logic              eng_rx_err,
  input  logic [LEN_W-1:0]  eng_rx_len
);
  // named internal events, also observed by the bound checker
  logic             ctl_we, data_we, buf_rx_we, finish_evt;
  logic             st_busy, st_done, st_tmo, st_rxe, st_bad, st_ien;
  logic [LEN_W-1:0] msg_size;
  logic [31:0]      ctl_word, buf_rd_word;

  assign ctl_we    = host_we && (host_waddr == '0);
  assign data_we   = host_we && (host_waddr != '0) && !st_busy;
  assign buf_rx_we = eng_rx_we && st_busy;

  aux_ctl_status #(.LEN_W(LEN_W), .MAX_BYTES(MSG_BYTES)) u_ctl (
    .clk, .rst_n,
    .ctl_we      (ctl_we),
    .ctl_wdata   (host_wdata),
    .eng_done    (eng_done),
    .eng_timeout (eng_timeout),
    .eng_rx_err  (eng_rx_err),
    .eng_rx_len  (eng_rx_len),
    .busy        (st_busy),
    .done        (st_done),
    .tmo_err     (st_tmo),
    .rx_err      (st_rxe),
    .size_bad    (st_bad),
    .irq_en      (st_ien),
    .msg_size    (msg_size),
    .start_pulse (eng_start),
    .finish_evt  (finish_evt)
  );

  aux_msg_buffer #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_buf (
    .clk, .rst_n,
    .host_we     (data_we),
    .host_word   (host_waddr - ADDR_W'(1)),
    .host_wdata  (host_wdata),
    .rx_we       (buf_rx_we),
    .rx_idx      (eng_rx_idx),
    .rx_byte     (eng_rx_byte),
    .rd_word_sel (host_raddr - ADDR_W'(1)),
    .rd_word     (buf_rd_word),
    .tx_idx      (eng_byte_idx),
    .tx_len      (msg_size),
    .tx_byte     (eng_tx_byte)
  );

  always_comb begin
    ctl_word                      = '0;
    ctl_word[BIT_BUSY]            = st_busy;
    ctl_word[BIT_DONE]            = st_done;
    ctl_word[BIT_TMO]             = st_tmo;
    ctl_word[BIT_RXE]             = st_rxe;
    ctl_word[BIT_BAD]             = st_bad;
    ctl_word[BIT_IEN]             = st_ien;
    ctl_word[SIZE_LSB +: LEN_W]   = msg_size;
  end

  assign host_rdata = (host_raddr == '0) ? ctl_word : buf_rd_word;
  assign eng_tx_len = msg_size;
  assign irq        = st_done && st_ien;
endmodule

// File: rtl/aux_msg_regbank_chk.sv
module aux_msg_regbank_chk
  import aux_regbank_pkg::*;
#(
  parameter int unsigned LEN_W     = 5,
  parameter int unsigned MAX_BYTES = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [31:0]      host_wdata,
  input logic             eng_start,
  input logic             eng_done,
  input logic [LEN_W-1:0] eng_rx_len,
  input logic             finish_evt,
  input logic             busy,
  input logic             done,
  input logic             size_bad,
  input logic             irq
);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy);

  assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (!busy && done));

  assert_w1c_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ctl_we && host_wdata[BIT_DONE] && !finish_evt) |=> !done);

  assert_size_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (size_bad == size_illegal(32'($past(eng_rx_len)), MAX_BYTES)));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !eng_start);

  assert_irq_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

bind aux_msg_regbank aux_msg_regbank_chk #(.LEN_W(LEN_W), .MAX_BYTES(MSG_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_we     (ctl_we),
  .host_wdata (host_wdata),
  .eng_start  (eng_start),
  .eng_done   (eng_done),
  .eng_rx_len (eng_rx_len),
  .finish_evt (finish_evt),
  .busy       (st_busy),
  .done       (st_done),
  .size_bad   (st_bad),
  .irq        (irq)
);

// File: tb/aux_msg_regbank_tb.sv
module aux_msg_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [2:0]  host_raddr = '0;
  logic [31:0] host_rdata;
  logic        irq, eng_start;
  logic [4:0]  eng_tx_len;
  logic [4:0]  eng_byte_idx = '0;
  logic [7:0]  eng_tx_byte;
  logic        eng_rx_we = 1'b0;
  logic [4:0]  eng_rx_idx = '0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_done = 1'b0, eng_timeout = 1'b0, eng_rx_err = 1'b0;
  logic [4:0]  eng_rx_len = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_msg_regbank u_dut (.*);

  // control word encoding, restated from the requirements
  localparam logic [31:0] C_BUSY = 32'h8000_0000;
  localparam logic [31:0] C_DONE = 32'h4000_0000;
  localparam logic [31:0] C_TMO  = 32'h2000_0000;
  localparam logic [31:0] C_RXE  = 32'h1000_0000;
  localparam logic [31:0] C_IEN  = 32'h0400_0000;

  function automatic logic [31:0] ctl(input bit b, input bit d, input bit t, input bit r,
                                      input bit bad, input bit ien, input int sz);
    return {b, d, t, r, bad, ien, 1'b0, 5'(sz), 20'h0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_raddr = a; #1;
    d = host_rdata;
  endtask

  task automatic tx_at(input int idx, output logic [7:0] b);
    @(negedge clk);
    eng_byte_idx = 5'(idx); #1;
    b = eng_tx_byte;
  endtask

  task automatic put_rx(input int idx, input logic [7:0] b);
    @(posedge clk); #1;
    eng_rx_we = 1'b1; eng_rx_idx = 5'(idx); eng_rx_byte = b;
    @(posedge clk); #1;
    eng_rx_we = 1'b0;
  endtask

  task automatic finish(input bit t, input bit r, input int len);
    @(posedge clk); #1;
    eng_done = 1'b1; eng_timeout = t; eng_rx_err = r; eng_rx_len = 5'(len);
    @(posedge clk); #1;
    eng_done = 1'b0; eng_timeout = 1'b0; eng_rx_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 ctl", d, 32'h0);
    for (int k = 1; k <= 5; k++) begin
      rd(3'(k), d); chk("R1 data", d, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 start", {31'h0, eng_start}, 32'h0);
  endtask

  task automatic t_pack_start();
    logic [31:0] d; logic [7:0] b;
    wr(3'd1, 32'hA1B2C3D4);
    wr(3'd2, 32'h11223344);
    rd(3'd1, d); chk("R2 word0", d, 32'hA1B2C3D4);
    rd(3'd2, d); chk("R2 word1", d, 32'h11223344);
    wr(3'd0, C_BUSY | (32'd6 << 20));
    chk("R4 start pulse", {31'h0, eng_start}, 32'h1);
    chk("R4 tx len", {27'h0, eng_tx_len}, 32'd6);
    @(posedge clk); #1;
    chk("R4 pulse width", {31'h0, eng_start}, 32'h0);
    rd(3'd0, d); chk("R4 busy", d, ctl(1, 0, 0, 0, 0, 0, 6));
    tx_at(0, b); chk("R2 byte0", {24'h0, b}, 32'hA1);
    tx_at(3, b); chk("R2 byte3", {24'h0, b}, 32'hD4);
    tx_at(4, b); chk("R2 byte4", {24'h0, b}, 32'h11);
    tx_at(5, b); chk("R2 byte5", {24'h0, b}, 32'h22);
    tx_at(6, b); chk("R3 beyond size", {24'h0, b}, 32'h00);
    tx_at(7, b); chk("R3 beyond size", {24'h0, b}, 32'h00);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    wr(3'd1, 32'hDEADBEEF);
    rd(3'd1, d); chk("R9 data frozen", d, 32'hA1B2C3D4);
    wr(3'd0, C_BUSY | (32'd9 << 20));
    chk("R10 no pulse", {31'h0, eng_start}, 32'h0);
    @(posedge clk); #1;
    chk("R10 no pulse later", {31'h0, eng_start}, 32'h0);
    chk("R10 len kept", {27'h0, eng_tx_len}, 32'd6);
    rd(3'd0, d); chk("R5 busy held", d, ctl(1, 0, 0, 0, 0, 0, 6));
  endtask

  task automatic t_complete();
    logic [31:0] d;
    put_rx(0, 8'h00);
    put_rx(1, 8'h5A);
    put_rx(2, 8'h77);
    finish(0, 0, 3);
    rd(3'd0, d); chk("R5 R7 done size", d, ctl(0, 1, 0, 0, 0, 0, 3));
    rd(3'd1, d); chk("R7 reply bytes", d, 32'h005A77D4);
    chk("R11 irq off", {31'h0, irq}, 32'h0);
    wr(3'd0, C_IEN);
    chk("R11 irq on", {31'h0, irq}, 32'h1);
    rd(3'd0, d); chk("R11 enable reads", d, ctl(0, 1, 0, 0, 0, 1, 3));
    wr(3'd0, C_IEN);
    rd(3'd0, d); chk("R6 zero keeps", d, ctl(0, 1, 0, 0, 0, 1, 3));
    wr(3'd0, C_IEN | C_DONE);
    rd(3'd0, d); chk("R6 clear done", d, ctl(0, 0, 0, 0, 0, 1, 3));
    chk("R11 irq drop", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] d;
    wr(3'd0, C_BUSY | C_IEN | (32'd4 << 20));
    finish(1, 0, 0);
    rd(3'd0, d); chk("R5 R8 timeout len0", d, ctl(0, 1, 1, 0, 1, 1, 0));
    wr(3'd0, C_IEN | C_TMO);
    rd(3'd0, d); chk("R6 clear only timeout", d, ctl(0, 1, 0, 0, 1, 1, 0));
    wr(3'd0, C_IEN | C_DONE);
    wr(3'd0, C_BUSY | C_IEN | (32'd2 << 20));
    rd(3'd0, d); chk("R8 start clears bad", d, ctl(1, 0, 0, 0, 0, 1, 2));
    finish(0, 1, 21);
    rd(3'd0, d); chk("R5 R8 rxerr len21", d, ctl(0, 1, 0, 1, 1, 1, 21));
    wr(3'd0, C_IEN | C_DONE | C_RXE);
    wr(3'd0, C_BUSY | C_IEN | (32'd1 << 20));
    finish(0, 0, 20);
    rd(3'd0, d); chk("R8 len20 legal", d, ctl(0, 1, 0, 0, 0, 1, 20));
    wr(3'd0, C_IEN | C_DONE);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(3'd0, C_BUSY | C_IEN | (32'd3 << 20));
    @(posedge clk); #1;
    host_we = 1'b1; host_waddr = 3'd0; host_wdata = C_IEN | C_DONE;
    eng_done = 1'b1; eng_rx_len = 5'd2;
    @(posedge clk); #1;
    host_we = 1'b0; eng_done = 1'b0;
    rd(3'd0, d); chk("R6 set wins", d, ctl(0, 1, 0, 0, 0, 1, 2));
    chk("R11 irq race", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", n_chk, n_chk);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pack_start();
    t_busy_ignore();
    t_complete();
    t_errors();
    t_race();
    repeat (2) @(posedge clk);
    summary();
  end
endmodule